// File: doc/BRIEF.md
# Audio Bit Clock and Master Clock Divider

This block sits beside the shifter of an audio serial port that runs as clock master. From a single fast kernel clock it produces three things: a serial bit clock, an optional master clock for an external converter, and a pair of one-cycle strobes that mark the bit-clock edges. The shifter uses the rising-edge strobe to sample input data and the falling-edge strobe to launch output data. All outputs are registered levels in the kernel clock domain.

The kernel clock first passes through a programmable primary divider. Its ratio is twice an 8-bit divide field plus an odd-adjust bit. A reshaping stage keeps the duty cycle close to half. When the master clock is enabled, the primary clock goes out as the master clock. The bit clock then follows after a further divide by 4 (32-bit channels) or by 8 (16-bit channels), so the master clock stays at 256 times the sample rate. When the master clock is disabled, the bit clock is the primary clock divided by 2 and the master clock stays low. The bit rate is the channel length times two channels times the sample rate.

Settings are captured while the block is disabled. While it runs, they are taken up only at the end of a full bit-clock period, so neither clock output ever shows a shortened or split pulse.

Top module: `audio_clkgen`

## Requirements
- R1: While reset is asserted, and on the first sample after it, mck_o, ck_o, ck_rise_o and ck_fall_o are all 0.
- R2: For a divide field D of 2 or more, the primary ratio N, in kernel cycles, is 2*D + odd_i.
- R3: Divide field values 0 and 1 act as D = 2 with odd_i ignored, so N = 4.
- R4: With mck_en_i = 1, mck_o repeats every N cycles and is high for (N+1)/2 of them (rounded down), so with N odd the high phase is one cycle longer than the low phase.
- R5: With mck_en_i = 1, the ck_o period is 4*N cycles when ch32_i = 1 and 8*N cycles when ch32_i = 0.
- R6: With mck_en_i = 0, the ck_o period is 2*N cycles and mck_o stays 0.
- R7: ck_o is high for exactly half of its period.
- R8: ck_rise_o is 1 in exactly the first cycle of each ck_o high phase, and ck_fall_o is 1 in exactly the first cycle of each low phase. Each fires once per period.
- R9: A change to div_i, odd_i, mck_en_i or ch32_i while en_i = 1 leaves the current ck_o period unchanged and applies from the next one.
- R10: One cycle after en_i is sampled 0, all outputs are 0, and they stay 0 while en_i remains 0. Settings presented while disabled are used from the start. The first cycle after en_i is sampled 1 starts a ck_o high phase with ck_rise_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Kernel clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable |
| div_i | input | DIV_W (8) | Primary divide field D |
| odd_i | input | 1 | Adds one to the primary ratio |
| mck_en_i | input | 1 | Drive master clock; selects deeper bit-clock divide |
| ch32_i | input | 1 | 1: 32-bit channels, 0: 16-bit channels |
| mck_o | output | 1 | Master clock |
| ck_o | output | 1 | Serial bit clock |
| ck_rise_o | output | 1 | One-cycle strobe at each ck_o rising edge |
| ck_fall_o | output | 1 | One-cycle strobe at each ck_o falling edge |

## Verification
The hardest case to reach is a reconfiguration during a run: a new setting arrives partway through a bit-clock period and must be held back until that period ends. The bench waits for a rising edge on ck_o, then changes both the divide field and the master-clock mode in the same cycle. It measures that period and the next one separately and expects the old length first, then the new one. Disabling in the middle of a high phase and re-enabling at once covers the restart path.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;
  // smallest legal divide field; smaller values fall back to it
  localparam int MIN_DIV     = 2;
  // post-divide ratios of the bit clock relative to the primary clock
  localparam int POST_PLAIN  = 2;
  localparam int POST_MCK_32 = 4;
  localparam int POST_MCK_16 = 8;
  localparam int POST_W      = $clog2(POST_MCK_16) + 1;
endpackage

// File: rtl/audio_clkgen_cfg.sv
module audio_clkgen_cfg
  import audio_clkgen_pkg::*;
#(
  parameter int DIV_W = 8,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              odd_i,
  input  logic              mck_en_i,
  input  logic              ch32_i,
  output logic [CNT_W-1:0]  ratio_o,
  output logic [CNT_W-1:0]  hi_o,
  output logic [POST_W-1:0] post_o,
  output logic              mck_on_o
);
  logic [CNT_W-1:0]  ratio_d;
  logic [CNT_W-1:0]  hi_d;
  logic [POST_W-1:0] post_d;

  always_comb begin
    if (div_i < DIV_W'(MIN_DIV))
      ratio_d = CNT_W'(2 * MIN_DIV);
    else
      ratio_d = {div_i, 1'b0} + CNT_W'(odd_i);
    // high phase gets the extra cycle of an odd ratio
    hi_d = CNT_W'(ratio_d[CNT_W-1:1]) + CNT_W'(ratio_d[0]);
    if (!mck_en_i)
      post_d = POST_W'(POST_PLAIN);
    else if (ch32_i)
      post_d = POST_W'(POST_MCK_32);
    else
      post_d = POST_W'(POST_MCK_16);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ratio_o  <= CNT_W'(2 * MIN_DIV);
      hi_o     <= CNT_W'(MIN_DIV);
      post_o   <= POST_W'(POST_PLAIN);
      mck_on_o <= 1'b0;
    end else if (load_i) begin
      ratio_o  <= ratio_d;
      hi_o     <= hi_d;
      post_o   <= post_d;
      mck_on_o <= mck_en_i;
    end
  end

  // R9: shadow settings hold between load points
  a_r9_cfg_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !load_i |=> ($stable(ratio_o) && $stable(post_o) && $stable(mck_on_o)));
  // R3: the ratio never drops below the legal floor
  a_r3_ratio_floor: assert property (@(posedge clk_i) disable iff (rst_i)
    ratio_o >= CNT_W'(2 * MIN_DIV));
endmodule

// File: rtl/audio_clkgen_prediv.sv
module audio_clkgen_prediv #(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = run_i && (cnt_q == ratio_i - 1'b1);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i)
      cnt_q <= '0;
    else if (wrap_o)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end

  // R2: the phase counter stays inside the programmed ratio
  a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q < ratio_i);
endmodule

// File: rtl/audio_clkgen_postdiv.sv
module audio_clkgen_postdiv #(
  parameter int POST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              run_i,
  input  logic              step_i,
  input  logic [POST_W-1:0] post_i,
  output logic [POST_W-1:0] pc_o,
  output logic              bnd_o
);
  logic [POST_W-1:0] pc_q;

  assign bnd_o = step_i && (pc_q == post_i - 1'b1);
  assign pc_o  = pc_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i)
      pc_q <= '0;
    else if (bnd_o)
      pc_q <= '0;
    else if (step_i)
      pc_q <= pc_q + 1'b1;
  end

  // R5: primary-period counter stays inside the post ratio
  a_r5_pc_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
    pc_q < post_i);
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import audio_clkgen_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             odd_i,
  input  logic             mck_en_i,
  input  logic             ch32_i,
  output logic             mck_o,
  output logic             ck_o,
  output logic             ck_rise_o,
  output logic             ck_fall_o
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0]  ratio;
  logic [CNT_W-1:0]  hi_len;
  logic [POST_W-1:0] post;
  logic              mck_on;
  logic [CNT_W-1:0]  cnt;
  logic              wrap;
  logic [POST_W-1:0] pc;
  logic              bnd;
  logic              load;
  logic [POST_W-1:0] half_post;

  // settings follow the inputs while idle, and only at a bit-clock period end while running
  assign load      = !en_i || bnd;
  assign half_post = post >> 1;

  audio_clkgen_cfg #(.DIV_W(DIV_W)) i_cfg (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .load_i   (load),
    .div_i    (div_i),
    .odd_i    (odd_i),
    .mck_en_i (mck_en_i),
    .ch32_i   (ch32_i),
    .ratio_o  (ratio),
    .hi_o     (hi_len),
    .post_o   (post),
    .mck_on_o (mck_on)
  );

  audio_clkgen_prediv #(.CNT_W(CNT_W)) i_prediv (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .run_i   (en_i),
    .ratio_i (ratio),
    .cnt_o   (cnt),
    .wrap_o  (wrap)
  );

  audio_clkgen_postdiv #(.POST_W(POST_W)) i_postdiv (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .run_i  (en_i),
    .step_i (wrap),
    .post_i (post),
    .pc_o   (pc),
    .bnd_o  (bnd)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mck_o     <= 1'b0;
      ck_o      <= 1'b0;
      ck_rise_o <= 1'b0;
      ck_fall_o <= 1'b0;
    end else begin
      mck_o     <= en_i && mck_on && (cnt < hi_len);
      ck_o      <= en_i && (pc < half_post);
      ck_rise_o <= en_i && (cnt == '0) && (pc == '0);
      ck_fall_o <= en_i && (cnt == '0) && (pc == half_post);
    end
  end

  // R8: rise strobe sits on the first high cycle
  a_r8_rise_on_edge: assert property (@(posedge clk_i) disable iff (rst_i)
    ck_rise_o |-> (ck_o && !$past(ck_o)));
  // R8: fall strobe sits on the first low cycle
  a_r8_fall_on_edge: assert property (@(posedge clk_i) disable iff (rst_i)
    ck_fall_o |-> (!ck_o && $past(ck_o)));
  // R8: no rising edge without its strobe
  a_r8_edge_has_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ck_o) |-> ck_rise_o);
  // R10: disabled means quiet outputs
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(!en_i) |-> (!ck_o && !mck_o && !ck_rise_o && !ck_fall_o));
  // R8: the two strobes never coincide
  a_r8_strobes_apart: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({ck_rise_o, ck_fall_o}));
endmodule

// File: tb/test_audio_clkgen.sv
module test_audio_clkgen;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  typedef struct packed {
    logic [7:0]  div;
    logic        odd;
    logic        mck;
    logic        ch32;
    logic [15:0] n;
    logic [15:0] m;
  } vec_t;

  // div, odd, mck_en, ch32, expected primary ratio, expected post ratio
  localparam vec_t VECS [NV] = '{
    '{8'd2,   1'b0, 1'b0, 1'b0, 16'd4,   16'd2},
    '{8'd3,   1'b1, 1'b0, 1'b1, 16'd7,   16'd2},
    '{8'd2,   1'b1, 1'b1, 1'b1, 16'd5,   16'd4},
    '{8'd3,   1'b0, 1'b1, 1'b0, 16'd6,   16'd8},
    '{8'd0,   1'b1, 1'b0, 1'b0, 16'd4,   16'd2},
    '{8'd1,   1'b1, 1'b1, 1'b1, 16'd4,   16'd4},
    '{8'd255, 1'b1, 1'b0, 1'b0, 16'd511, 16'd2},
    '{8'd9,   1'b1, 1'b1, 1'b0, 16'd19,  16'd8}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [7:0] div = 8'd2;
  logic       odd = 1'b0;
  logic       mck_en = 1'b0;
  logic       ch32 = 1'b0;
  logic       mck_o, ck_o, ck_rise_o, ck_fall_o;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  audio_clkgen #(.DIV_W(8)) i_audio_clkgen (
    .clk_i     (clk),
    .rst_i     (rst),
    .en_i      (en),
    .div_i     (div),
    .odd_i     (odd),
    .mck_en_i  (mck_en),
    .ch32_i    (ch32),
    .mck_o     (mck_o),
    .ck_o      (ck_o),
    .ck_rise_o (ck_rise_o),
    .ck_fall_o (ck_fall_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance until a sample shows ck_o just risen
  task automatic wait_rise();
    logic prev;
    prev = ck_o;
    @(negedge clk);
    while (!(ck_o && !prev)) begin
      prev = ck_o;
      @(negedge clk);
    end
  endtask

  // called on the first high sample; returns on the next first high sample
  task automatic measure(output int hc, output int lc, output int mh,
                         output int rc, output int fc,
                         output int first_r, output int first_f);
    hc = 0; lc = 0; mh = 0; rc = 0; fc = 0;
    first_r = int'(ck_rise_o);
    while (ck_o) begin
      hc++; mh += int'(mck_o); rc += int'(ck_rise_o); fc += int'(ck_fall_o);
      @(negedge clk);
    end
    first_f = int'(ck_fall_o);
    while (!ck_o) begin
      lc++; mh += int'(mck_o); rc += int'(ck_rise_o); fc += int'(ck_fall_o);
      @(negedge clk);
    end
  endtask

  task automatic setup(input logic [7:0] d, input logic o, input logic m, input logic c);
    en = 1'b0;
    @(negedge clk);
    div = d; odd = o; mck_en = m; ch32 = c;
    @(negedge clk);
    en = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int hc, lc, mh, rc, fc, fr, ff, hi, quiet;
    repeat (3) @(negedge clk);
    // R1: outputs low in reset
    check("R1", int'({mck_o, ck_o, ck_rise_o, ck_fall_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", int'({mck_o, ck_o, ck_rise_o, ck_fall_o}), 0);

    for (int v = 0; v < NV; v++) begin
      setup(VECS[v].div, VECS[v].odd, VECS[v].mck, VECS[v].ch32);
      wait_rise();
      measure(hc, lc, mh, rc, fc, fr, ff);
      hi = (int'(VECS[v].n) + 1) / 2;
      check((VECS[v].div < 2) ? "R3" : "R2", (hc + lc) / int'(VECS[v].m), int'(VECS[v].n));
      check(VECS[v].mck ? "R5" : "R6", hc + lc, int'(VECS[v].m) * int'(VECS[v].n));
      check("R7", hc, lc);
      if (VECS[v].mck) check("R4", mh, int'(VECS[v].m) * hi);
      else             check("R6", mh, 0);
      check("R8", rc * 10 + fc, 11);
      check("R8", fr * 10 + ff, 11);
    end

    // R9: change settings right after a rising edge
    setup(8'd2, 1'b0, 1'b0, 1'b0);
    wait_rise();
    div = 8'd3; mck_en = 1'b1; ch32 = 1'b1;
    measure(hc, lc, mh, rc, fc, fr, ff);
    check("R9", hc * 1000 + lc, 4 * 1000 + 4);
    check("R9", mh, 0);
    measure(hc, lc, mh, rc, fc, fr, ff);
    check("R9", hc * 1000 + lc, 12 * 1000 + 12);
    check("R9", mh, 4 * 3);

    // R10: disable in the middle of a high phase
    wait_rise();
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check("R10", int'({mck_o, ck_o, ck_rise_o, ck_fall_o}), 0);
    quiet = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      quiet += int'(mck_o) + int'(ck_o) + int'(ck_rise_o) + int'(ck_fall_o);
    end
    check("R10", quiet, 0);
    en = 1'b1;
    @(negedge clk);
    check("R10", int'({ck_o, ck_rise_o}), 3);

    // R1: reset while running
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", int'({mck_o, ck_o, ck_rise_o, ck_fall_o}), 0);
    rst = 1'b0;
    en = 1'b0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule